// File: doc/BRIEF.md
# Keyboard Packet Scancode Extractor

This block sits behind a link receive controller that delivers whole packets. Each packet arrives in one transfer as a flat byte array plus a length. The block keeps only keyboard-event packets. It takes the two scancode slots out of each kept packet and sends the non-empty ones, one byte per transfer, to a downstream consumer such as a key-event queue. Packets that fail the header check, and packets too short to hold both slots, are thrown away. A saturating counter reports how many were thrown away.

Both data interfaces are valid/ready. A transfer happens on a rising clock edge where valid and ready are both high.

Back-pressure works as follows:
- The packet side is ready only when no scancode from an earlier packet is still waiting.
- Once a scancode is offered, it is held steady until the consumer takes it.
- After the last scancode of a packet has been taken, the packet side becomes ready one cycle later.
- A packet that yields no output never blocks: the packet side stays ready through it.

Top module: `kbx_scancode_extract`

## Requirements
- R1: A packet is kept only if byte 0 is 0x00 and byte 1 is 0x40. Otherwise it is dropped with no output. Byte i is carried on pkt_data bits [8i+7:8i].
- R2: A packet is kept only if byte 2 is 0x2C or 0x8C. Any other value in byte 2 drops the packet with no output.
- R3: A packet whose pkt_len is below 5 is dropped with no output, whatever its bytes hold.
- R4: In a kept packet, byte 3 is the first slot and byte 4 is the second slot. A slot holding 0xFF is empty and produces no output, so key_data never carries 0xFF.
- R5: When both slots of a kept packet are non-empty, the byte 3 value is emitted before the byte 4 value.
- R6: While a scancode is offered or still pending, pkt_ready is low. An offered byte holds key_valid high and key_data stable until key_ready accepts it. pkt_ready returns high in the cycle after the last byte is taken.
- R7: A dropped packet, or a kept packet whose two slots are both empty, is consumed in its transfer cycle. pkt_ready stays high and key_valid stays low in the following cycle.
- R8: drop_count increments by one for each dropped packet (R1, R2, R3). It holds at 2^CNT_W-1 once it reaches that value. Kept packets do not change it.
- R9: After reset, pkt_ready is 1, key_valid is 0 and drop_count is 0.
- R10: When a transfer delivers a kept packet with at least one non-empty slot, key_valid is high in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | A whole packet is offered |
| pkt_ready | output | 1 | The block can take a packet |
| pkt_data | input | 8*MAX_LEN | Packet bytes, byte i in bits [8i+7:8i] |
| pkt_len | input | $clog2(MAX_LEN+1) | Number of valid bytes in the packet |
| key_valid | output | 1 | A scancode is offered |
| key_ready | input | 1 | The consumer takes the offered scancode |
| key_data | output | 8 | Scancode byte |
| drop_count | output | CNT_W | Saturating count of dropped packets |

## Verification
The hardest situation to reach is a two-scancode packet whose first byte is stalled by the consumer while the second byte waits behind it. It must be checked both that the held byte stays steady and that no new packet slips in before the second byte leaves. The bench reaches this case by sweeping every slot pairing, including the 0xFF marker in either slot, across all header and length combinations. While doing so it drives key_ready from an arithmetic pattern that stalls on some cycles and accepts on others, so every pending depth meets both stalls and immediate takes. The same sweep sends well over 255 dropped packets, which pushes drop_count into saturation.

// File: rtl/kbx_pkg.sv
package kbx_pkg;
  localparam logic [7:0] HDR_B0    = 8'h00;
  localparam logic [7:0] HDR_B1    = 8'h40;
  localparam logic [7:0] KIND_A    = 8'h2C;
  localparam logic [7:0] KIND_B    = 8'h8C;
  localparam logic [7:0] EMPTY_KEY = 8'hFF;
  localparam int         MIN_LEN   = 5;
  localparam int         SLOT_BASE = 3;
  localparam int         NSLOT     = 2;

  typedef struct packed {
    logic                       keep;
    logic [NSLOT-1:0]           slot_ok;
    logic [NSLOT-1:0][7:0]      slot;
  } kbx_class_t;
endpackage

// File: rtl/kbx_hdr_check.sv
module kbx_hdr_check
  import kbx_pkg::*;
#(
  parameter int MAX_LEN = 8,
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic [8*MAX_LEN-1:0] data,
  input  logic [LEN_W-1:0]     len,
  output kbx_class_t           cls
);
  logic [7:0] b0, b1, b2;
  logic       len_ok, hdr_ok, kind_ok;

  assign b0      = data[7:0];
  assign b1      = data[15:8];
  assign b2      = data[23:16];
  assign len_ok  = (len >= LEN_W'(MIN_LEN));
  assign hdr_ok  = (b0 == HDR_B0) && (b1 == HDR_B1);
  assign kind_ok = (b2 == KIND_A) || (b2 == KIND_B);
  assign cls.keep = len_ok && hdr_ok && kind_ok;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign cls.slot[g]    = data[8*(SLOT_BASE+g) +: 8];
    assign cls.slot_ok[g] = cls.keep && (cls.slot[g] != EMPTY_KEY);
  end
endmodule

// File: rtl/kbx_slot_seq.sv
module kbx_slot_seq
  import kbx_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [NSLOT-1:0]      slot_ok,
  input  logic [NSLOT-1:0][7:0] slot,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [7:0]            out_data,
  output logic                  idle
);
  logic [1:0] pend;
  logic [7:0] q0, q1;
  logic       take;

  assign out_valid = (pend != 2'd0);
  assign out_data  = q0;
  assign idle      = (pend == 2'd0);
  assign take      = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 2'd0;
      q0   <= 8'h00;
      q1   <= 8'h00;
    end else if (load && idle) begin
      case (slot_ok)
        2'b11:   begin q0 <= slot[0]; q1 <= slot[1]; pend <= 2'd2; end
        2'b01:   begin q0 <= slot[0]; pend <= 2'd1; end
        2'b10:   begin q0 <= slot[1]; pend <= 2'd1; end
        default: pend <= 2'd0;
      endcase
    end else if (take) begin
      q0   <= q1;
      pend <= pend - 2'd1;
    end
  end

  // R6: an offered byte that is not taken stays offered and unchanged
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/kbx_drop_ctr.sv
module kbx_drop_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n)                    count <= '0;
    else if (inc && count != TOP)  count <= count + 1'b1;
  end

  // R8: saturation holds the top value
  a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && count == TOP) |=> (count == TOP));
  // R8: below the top, each drop adds exactly one
  a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && count != TOP) |=> (count == $past(count) + 1'b1));
  // R8: no drop, no change
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(count));
endmodule

// File: rtl/kbx_scancode_extract.sv
module kbx_scancode_extract
  import kbx_pkg::*;
#(
  parameter int MAX_LEN = 8,
  parameter int CNT_W   = 8,
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pkt_valid,
  output logic                 pkt_ready,
  input  logic [8*MAX_LEN-1:0] pkt_data,
  input  logic [LEN_W-1:0]     pkt_len,
  output logic                 key_valid,
  input  logic                 key_ready,
  output logic [7:0]           key_data,
  output logic [CNT_W-1:0]     drop_count
);
  kbx_class_t cls;
  logic       accept, load, drop_inc, seq_idle;

  kbx_hdr_check #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_hdr (
    .data (pkt_data),
    .len  (pkt_len),
    .cls  (cls)
  );

  assign pkt_ready = seq_idle;
  assign accept    = pkt_valid && pkt_ready;
  assign load      = accept && (|cls.slot_ok);
  assign drop_inc  = accept && !cls.keep;

  kbx_slot_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .slot_ok   (cls.slot_ok),
    .slot      (cls.slot),
    .out_valid (key_valid),
    .out_ready (key_ready),
    .out_data  (key_data),
    .idle      (seq_idle)
  );

  kbx_drop_ctr #(.CNT_W(CNT_W)) u_drop (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (drop_inc),
    .count (drop_count)
  );

  // R4: the empty marker never leaves the block
  a_r4_no_empty_out: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> (key_data != EMPTY_KEY));
  // R6: no packet is taken while a scancode is offered
  a_r6_in_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> !pkt_ready);
  // R10: a productive packet shows output in the next cycle
  a_r10_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> key_valid);
  // R7: a packet with nothing to emit leaves the input ready
  a_r7_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !load) |=> (pkt_ready && !key_valid));
endmodule

// File: tb/tb_kbx_scancode_extract.sv
module tb_kbx_scancode_extract;
  localparam int MAX_LEN = 8;
  localparam int CNT_W   = 8;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);
  localparam int TOPCNT  = (1 << CNT_W) - 1;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 pkt_valid = 1'b0;
  logic                 pkt_ready;
  logic [8*MAX_LEN-1:0] pkt_data = '0;
  logic [LEN_W-1:0]     pkt_len = '0;
  logic                 key_valid;
  logic                 key_ready = 1'b0;
  logic [7:0]           key_data;
  logic [CNT_W-1:0]     drop_count;

  kbx_scancode_extract #(.MAX_LEN(MAX_LEN), .CNT_W(CNT_W)) dut (
    .clk, .rst_n, .pkt_valid, .pkt_ready, .pkt_data, .pkt_len,
    .key_valid, .key_ready, .key_data, .drop_count
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int stall_ctr = 0;
  int exp_drop = 0;
  logic [7:0] pk [MAX_LEN];

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    stall_ctr++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below %0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // Drives one packet from pk/len and checks everything it should cause.
  task automatic run_pkt(input int len, input int mode);
    bit   hdr_ok, kind_ok, len_ok, keep;
    int   expn, got, guard;
    logic [7:0] expq [2];
    logic [7:0] held;
    bit   stalled;
    string why;
    len_ok  = (len >= 5);
    hdr_ok  = (pk[0] == 8'h00) && (pk[1] == 8'h40);
    kind_ok = (pk[2] == 8'h2C) || (pk[2] == 8'h8C);
    keep    = len_ok && hdr_ok && kind_ok;
    why     = !len_ok ? "R3 short" : (!hdr_ok ? "R1 header" : "R2 kind");
    expn = 0;
    if (keep && pk[3] != 8'hFF) begin expq[expn] = pk[3]; expn++; end
    if (keep && pk[4] != 8'hFF) begin expq[expn] = pk[4]; expn++; end

    chk(pkt_ready == 1'b1, "R7 ready before packet", int'(pkt_ready), 1);
    for (int i = 0; i < MAX_LEN; i++) pkt_data[8*i +: 8] = pk[i];
    pkt_len   = LEN_W'(len);
    pkt_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    pkt_valid = 1'b0;
    pkt_data  = {MAX_LEN{8'hA5}};

    if (!keep) begin
      if (exp_drop < TOPCNT) exp_drop++;
      chk(key_valid == 1'b0, why, int'(key_valid), 0);
      chk(int'(drop_count) == exp_drop, "R8 drop count", int'(drop_count), exp_drop);
      chk(pkt_ready == 1'b1, "R7 dropped consumed", int'(pkt_ready), 1);
    end else if (expn == 0) begin
      chk(key_valid == 1'b0, "R4 both slots empty", int'(key_valid), 0);
      chk(pkt_ready == 1'b1, "R7 empty consumed", int'(pkt_ready), 1);
      chk(int'(drop_count) == exp_drop, "R8 kept no count", int'(drop_count), exp_drop);
    end else begin
      chk(key_valid == 1'b1, "R10 output next cycle", int'(key_valid), 1);
      got = 0;
      guard = 0;
      while (got < expn && guard < 60) begin
        key_ready = (((stall_ctr * 7) + mode) % 5) >= 2;
        stalled = 1'b0;
        if (key_valid) begin
          chk(pkt_ready == 1'b0, "R6 input blocked", int'(pkt_ready), 0);
          if (key_ready) begin
            chk(key_data == expq[got], (expn == 2) ? "R5 order" : "R4 single slot",
                int'(key_data), int'(expq[got]));
            got++;
          end else begin
            stalled = 1'b1;
            held = key_data;
          end
        end
        @(posedge clk);
        @(negedge clk);
        if (stalled)
          chk(key_valid && key_data == held, "R6 hold under stall", int'(key_data), int'(held));
        guard++;
      end
      key_ready = 1'b0;
      chk(got == expn, "R6 all bytes delivered", got, expn);
      chk(!key_valid && pkt_ready, "R6 release after last", int'(pkt_ready), 1);
      chk(int'(drop_count) == exp_drop, "R8 kept no count", int'(drop_count), exp_drop);
    end
  endtask

  initial begin
    logic [7:0] b0s [4];
    logic [7:0] b1s [4];
    logic [7:0] sls [4];
    b0s = '{8'h00, 8'h01, 8'h80, 8'hFF};
    b1s = '{8'h40, 8'h00, 8'h41, 8'hC0};
    sls = '{8'h1C, 8'hFF, 8'h00, 8'h9E};
    for (int i = 0; i < MAX_LEN; i++) pk[i] = 8'h00;

    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pkt_ready == 1'b1, "R9 reset ready", int'(pkt_ready), 1);
    chk(key_valid == 1'b0, "R9 reset valid", int'(key_valid), 0);
    chk(drop_count == '0, "R9 reset count", int'(drop_count), 0);

    // Sweep 1: every byte-2 value with a good header and two live slots (R2)
    for (int k = 0; k < 256; k++) begin
      pk[0] = 8'h00; pk[1] = 8'h40; pk[2] = 8'(k);
      pk[3] = 8'h1C; pk[4] = 8'h32; pk[5] = 8'h77;
      run_pkt(5, k % 5);
    end

    // Sweep 2: header pairs x kind x slot pairs x every length (R1 R3 R4 R5)
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 2; c++)
          for (int s = 0; s < 16; s++)
            for (int l = 0; l <= MAX_LEN; l++) begin
              pk[0] = b0s[a]; pk[1] = b1s[b];
              pk[2] = c ? 8'h8C : 8'h2C;
              pk[3] = sls[s % 4]; pk[4] = sls[s / 4];
              pk[5] = 8'hFF; pk[6] = 8'h12; pk[7] = 8'hFF;
              run_pkt(l, s + l);
            end

    chk(int'(drop_count) == TOPCNT, "R8 saturated", int'(drop_count), TOPCNT);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule